// File: doc/BRIEF.md
# Fractional Sliding-Mode Control Datapath

This block turns one set of plant measurements into one fixed-point control value for each sample strobe. It takes a tracking reference and its fractional derivative, two plant states (`x3`, `x4`) and a reciprocal of the total-population state. It forms the tracking error `e = x4 - ref` and the sliding variable `S = e + C1 * Dα(e)`. The control value is the sum of an equivalent term and a switching term. The switching term is a sign (or clamped linear) function of `S` passed through a fractional-order integrator. Both fractional operators are first-order IIR sections. Their histories advance only when a sample is processed.

All arithmetic is 22-bit signed two's complement with 16 fraction bits, so 1.0 is 65536. Each product is rounded half-up and every stage result saturates to the 22-bit range. No divider is present: the caller supplies `1/x5`, and the block stores `1/c1` and `kd/c1` as constants. The intended clock domain runs at 10 MHz.

A controller FSM steps through five states:

- **ST_IDLE** waits for a strobe. The transition ST_IDLE→ST_SLIDE happens on an accepted strobe and captures the inputs and the error.
- **ST_SLIDE** steps the derivative filter and forms `S`. It moves to ST_SWITCH.
- **ST_SWITCH** steps the integrator on the switching value. It moves to ST_BLEND.
- **ST_BLEND** forms the bracketed control term. It moves to ST_SCALE.
- **ST_SCALE** multiplies by the reciprocal, registers the output with its valid flag, and returns to ST_IDLE.

Top module: `slide_ctrl`

## Requirements
- R1: While reset is low, `u_out` is 0 and `u_valid` is 0. After reset, both filter histories are zero, so the first sample behaves as if all past inputs and outputs were 0.
- R2: The error is `e = sat(x4 - ref_in)`. The derivative filter gives `d = sat(r(1.5·e) + r(-1.25·e_prev) - r(-0.5·d_prev))`. The sliding variable is `S = sat(e + sat(r(0.5·d)))`. Here `r()` is a Q16 product rounded half-up and `sat()` clamps to the 22-bit range.
- R3: With `sat_mode`=0, the switching value is +65536 when S>0, -65536 when S<0, and 0 when S=0.
- R4: With `sat_mode`=1, the switching value is `r(4.0·S)` clamped to [-65536, +65536]. `sat_mode` is sampled with the strobe.
- R5: The integrator gives `i = sat(r(0.25·w) + r(0.125·w_prev) - r(-0.875·i_prev))`, where `w` is the switching value.
- R6: The output is `u = sat(r(x5_inv · B))`, where `B = sat(r(0.3·x4) - r(0.2·x3) + ref_dfrac - r(2.0·e) - r(0.4·i))`.
- R7: `u_valid` is high for exactly one cycle. It rises on the fifth rising edge counting the edge that samples the strobe, and `u_out` updates on that same edge.
- R8: A strobe that arrives while a sample is in progress is ignored. It produces no extra valid pulse, does not change the result in progress, and does not advance the filter histories.
- R9: Out-of-range intermediates and outputs saturate to +2097151 or -2097152 rather than wrapping.
- R10: `u_out` holds its value in every cycle in which `u_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Start one control sample (accepted in ST_IDLE only) |
| sat_mode | input | 1 | 0: sign switching, 1: clamped linear switching |
| x3 | input | 22 | Plant state x3, Q16 signed |
| x4 | input | 22 | Plant state x4, Q16 signed |
| x5_inv | input | 22 | Reciprocal of state x5, Q16 signed |
| ref_in | input | 22 | Tracking reference, Q16 signed |
| ref_dfrac | input | 22 | Fractional derivative of the reference, Q16 signed |
| u_out | output | 22 | Control value, Q16 signed |
| u_valid | output | 1 | One-cycle flag marking a new `u_out` |

## Verification
The only observable result is `u_out` together with `u_valid`. Both change on the fifth rising edge counted from the edge that samples the strobe. The bench drives inputs on falling edges. It checks that `u_valid` is still low after the fourth edge, checks value and flag after the fifth edge, and checks the pulse has ended with the value held after the sixth. The effects of the filter histories and of ignored strobes show up only as the values of later samples, so the bench keeps its own model histories and compares every sample in order.

// File: rtl/slide_pkg.sv
package slide_pkg;
    localparam int DW = 22;
    localparam int FW = 16;
    localparam int AW = 2 * DW + 4;

    typedef logic signed [DW-1:0] fx_t;
    typedef logic signed [AW-1:0] acc_t;

    localparam fx_t FX_MAX     = fx_t'({1'b0, {(DW-1){1'b1}}});
    localparam fx_t FX_MIN     = fx_t'({1'b1, {(DW-1){1'b0}}});
    localparam fx_t FX_ONE     = fx_t'(1 << FW);
    localparam fx_t FX_NEG_ONE = fx_t'(-(1 << FW));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLIDE,
        ST_SWITCH,
        ST_BLEND,
        ST_SCALE
    } state_t;

    function automatic acc_t fx_ext(input fx_t a);
        return acc_t'(a);
    endfunction

    // Q16 product, rounded half-up, not yet saturated
    function automatic acc_t fx_mulr(input fx_t a, input fx_t b);
        acc_t p;
        p = fx_ext(a) * fx_ext(b);
        return (p + (acc_t'(1) <<< (FW - 1))) >>> FW;
    endfunction

    function automatic fx_t fx_sat(input acc_t v);
        if (v > fx_ext(FX_MAX)) begin
            return FX_MAX;
        end else if (v < fx_ext(FX_MIN)) begin
            return FX_MIN;
        end else begin
            return fx_t'(v[DW-1:0]);
        end
    endfunction

    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        return fx_sat(fx_mulr(a, b));
    endfunction
endpackage

// File: rtl/slide_fracop.sv
module slide_fracop
    import slide_pkg::*;
#(
    parameter fx_t B0 = fx_t'(98304),
    parameter fx_t B1 = fx_t'(-81920),
    parameter fx_t A1 = fx_t'(-32768)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  fx_t  x,
    output fx_t  y
);
    fx_t x_prev;
    fx_t y_prev;

    // First-order section: y = b0*x + b1*x[-1] - a1*y[-1]
    assign y = fx_sat(fx_mulr(B0, x) + fx_mulr(B1, x_prev) - fx_mulr(A1, y_prev));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_prev <= '0;
            y_prev <= '0;
        end else if (en) begin
            x_prev <= x;
            y_prev <= y;
        end
    end
endmodule

// File: rtl/slide_switch.sv
module slide_switch
    import slide_pkg::*;
#(
    parameter fx_t INV_PHI = fx_t'(262144)
) (
    input  logic sat_mode,
    input  fx_t  s,
    output fx_t  sw
);
    acc_t scaled;
    fx_t  sgn;
    fx_t  clip;

    always_comb begin
        if (s > 0) begin
            sgn = FX_ONE;
        end else if (s < 0) begin
            sgn = FX_NEG_ONE;
        end else begin
            sgn = '0;
        end

        scaled = fx_mulr(INV_PHI, s);
        if (scaled > fx_ext(FX_ONE)) begin
            clip = FX_ONE;
        end else if (scaled < fx_ext(FX_NEG_ONE)) begin
            clip = FX_NEG_ONE;
        end else begin
            clip = fx_t'(scaled[DW-1:0]);
        end

        sw = sat_mode ? clip : sgn;
    end
endmodule

// File: rtl/slide_ctrl.sv
module slide_ctrl
    import slide_pkg::*;
#(
    parameter fx_t P_C1     = fx_t'(32768),
    parameter fx_t P_INV_C1 = fx_t'(131072),
    parameter fx_t P_KD_C1  = fx_t'(26214),
    parameter fx_t P_UW     = fx_t'(19661),
    parameter fx_t P_GAM    = fx_t'(13107),
    parameter fx_t P_INV_PHI = fx_t'(262144),
    parameter fx_t P_DB0    = fx_t'(98304),
    parameter fx_t P_DB1    = fx_t'(-81920),
    parameter fx_t P_DA1    = fx_t'(-32768),
    parameter fx_t P_IB0    = fx_t'(16384),
    parameter fx_t P_IB1    = fx_t'(8192),
    parameter fx_t P_IA1    = fx_t'(-57344)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic                 sat_mode,
    input  logic signed [DW-1:0] x3,
    input  logic signed [DW-1:0] x4,
    input  logic signed [DW-1:0] x5_inv,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] ref_dfrac,
    output logic signed [DW-1:0] u_out,
    output logic                 u_valid
);
    state_t state;
    state_t nxt;
    logic   accept;

    fx_t e_q, x3_q, x4_q, dref_q, inv_q;
    logic mode_q;
    fx_t s_q, ie_q, inner_q;
    fx_t de_w, sw_w, ie_w;

    assign accept = strobe && (state == ST_IDLE);

    slide_fracop #(.B0(P_DB0), .B1(P_DB1), .A1(P_DA1)) i_deriv (
        .clk(clk), .rst_n(rst_n), .en(state == ST_SLIDE), .x(e_q), .y(de_w)
    );

    slide_switch #(.INV_PHI(P_INV_PHI)) i_switch (
        .sat_mode(mode_q), .s(s_q), .sw(sw_w)
    );

    slide_fracop #(.B0(P_IB0), .B1(P_IB1), .A1(P_IA1)) i_integ (
        .clk(clk), .rst_n(rst_n), .en(state == ST_SWITCH), .x(sw_w), .y(ie_w)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (strobe) nxt = ST_SLIDE;
            ST_SLIDE:  nxt = ST_SWITCH;
            ST_SWITCH: nxt = ST_BLEND;
            ST_BLEND:  nxt = ST_SCALE;
            ST_SCALE:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q     <= '0;
            x3_q    <= '0;
            x4_q    <= '0;
            dref_q  <= '0;
            inv_q   <= '0;
            mode_q  <= 1'b0;
            s_q     <= '0;
            ie_q    <= '0;
            inner_q <= '0;
            u_out   <= '0;
            u_valid <= 1'b0;
        end else begin
            u_valid <= (state == ST_SCALE);
            if (accept) begin
                e_q    <= fx_sat(fx_ext(x4) - fx_ext(ref_in));
                x3_q   <= x3;
                x4_q   <= x4;
                dref_q <= ref_dfrac;
                inv_q  <= x5_inv;
                mode_q <= sat_mode;
            end
            if (state == ST_SLIDE) begin
                s_q <= fx_sat(fx_ext(e_q) + fx_ext(fx_mul(P_C1, de_w)));
            end
            if (state == ST_SWITCH) begin
                ie_q <= ie_w;
            end
            if (state == ST_BLEND) begin
                inner_q <= fx_sat(fx_mulr(P_UW, x4_q) - fx_mulr(P_GAM, x3_q)
                                  + fx_ext(dref_q) - fx_mulr(P_INV_C1, e_q)
                                  - fx_mulr(P_KD_C1, ie_q));
            end
            if (state == ST_SCALE) begin
                u_out <= fx_mul(inv_q, inner_q);
            end
        end
    end
endmodule

// File: rtl/slide_ctrl_chk.sv
module slide_ctrl_chk
    import slide_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic accept,
    input logic u_valid,
    input fx_t  u_out,
    input fx_t  sw_val
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (u_out == '0 && !u_valid)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        u_valid |-> $past(accept, 5)); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        u_valid |=> !u_valid); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !u_valid |-> $stable(u_out)); // R10

    AST_SWITCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_val <= FX_ONE) && (sw_val >= FX_NEG_ONE)); // R4
endmodule

bind slide_ctrl slide_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .u_valid(u_valid), .u_out(u_out), .sw_val(sw_w)
);

// File: tb/test_slide_ctrl.sv
`timescale 1ns/1ps
module test_slide_ctrl;
    localparam longint ONE = 65536;
    localparam longint VMAX = 2097151;
    localparam longint VMIN = -2097152;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic sat_mode = 1'b0;
    logic signed [21:0] x3 = '0, x4 = '0, x5_inv = '0, ref_in = '0, ref_dfrac = '0;
    logic signed [21:0] u_out;
    logic u_valid;

    int checks = 0;
    int fails = 0;
    longint dxp = 0, dyp = 0, ixp = 0, iyp = 0;

    always #4 clk = ~clk;

    slide_ctrl i_slide_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sat_mode(sat_mode),
        .x3(x3), .x4(x4), .x5_inv(x5_inv), .ref_in(ref_in), .ref_dfrac(ref_dfrac),
        .u_out(u_out), .u_valid(u_valid)
    );

    function automatic longint mr(longint a, longint b);
        return (a * b + 32768) >>> 16;
    endfunction

    function automatic longint sat(longint v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        dxp = 0; dyp = 0; ixp = 0; iyp = 0;
    endtask

    // Reference model of one sample (R2..R6, R9)
    task automatic model(input longint a3, a4, ainv, ar, adr, input bit md, output longint u);
        longint e, d, s, w, t, i, b;
        e = sat(a4 - ar);
        d = sat(mr(98304, e) + mr(-81920, dxp) - mr(-32768, dyp));
        dxp = e; dyp = d;
        s = sat(e + sat(mr(32768, d)));
        if (md) begin
            t = mr(262144, s);
            w = (t > ONE) ? ONE : ((t < -ONE) ? -ONE : t);
        end else begin
            w = (s > 0) ? ONE : ((s < 0) ? -ONE : 0);
        end
        i = sat(mr(16384, w) + mr(8192, ixp) - mr(-57344, iyp));
        ixp = w; iyp = i;
        b = sat(mr(19661, a4) - mr(13107, a3) + adr - mr(131072, e) - mr(26214, i));
        u = sat(mr(ainv, b));
    endtask

    task automatic drive(input longint a3, a4, ainv, ar, adr, input bit md);
        x3 = 22'(a3); x4 = 22'(a4); x5_inv = 22'(ainv);
        ref_in = 22'(ar); ref_dfrac = 22'(adr); sat_mode = md;
    endtask

    task automatic run_sample(input longint a3, a4, ainv, ar, adr, input bit md, input string req);
        longint exp, held;
        model(a3, a4, ainv, ar, adr, md, exp);
        @(negedge clk); drive(a3, a4, ainv, ar, adr, md); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 early", longint'(u_valid), 0);
        @(negedge clk);
        check("R7 due", longint'(u_valid), 1);
        check(req, longint'(u_out), exp);
        held = longint'(u_out);
        @(negedge clk);
        check("R7 width", longint'(u_valid), 0);
        check("R10", longint'(u_out), held);
    endtask

    // R8: second strobe while busy
    task automatic busy_sample(input longint a3, a4, ainv, ar, adr, input bit md);
        longint exp, seen;
        int pulses;
        model(a3, a4, ainv, ar, adr, md, exp);
        @(negedge clk); drive(a3, a4, ainv, ar, adr, md); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        @(negedge clk); drive(-a3, -a4, ainv, ar + 4 * ONE, adr, ~md); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        pulses = 0; seen = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (u_valid) begin pulses++; seen = longint'(u_out); end
        end
        check("R8 pulses", longint'(pulses), 1);
        check("R8 value", seen, exp);
    endtask

    function automatic longint rnd(longint r);
        return longint'($urandom_range(0, 32'(2 * r))) - r;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 out", longint'(u_out), 0);
        check("R1 valid", longint'(u_valid), 0);
        rst_n = 1'b1;
        model_reset();

        // R3 zero code: S = 0 on clean history
        run_sample(ONE / 2, ONE, ONE, ONE, ONE / 4, 1'b0, "R3 zero");
        run_sample(0, 2 * ONE, ONE, ONE, 0, 1'b0, "R3 pos");
        run_sample(0, -ONE, ONE, ONE, 0, 1'b0, "R3 neg");
        run_sample(ONE, ONE + 655, 2 * ONE, ONE, 0, 1'b1, "R4 linear");
        run_sample(ONE, 3 * ONE, 2 * ONE, 0, 0, 1'b1, "R4 clamp");
        run_sample(ONE, 2 * ONE, ONE, 3 * ONE, ONE, 1'b0, "R5");

        // R9 saturation of error and output
        run_sample(0, 30 * ONE, 31 * ONE, -30 * ONE, 0, 1'b0, "R9 low");
        run_sample(-30 * ONE, -30 * ONE, 31 * ONE, 30 * ONE, 10 * ONE, 1'b1, "R9 high");

        // R1: mid-run reset clears histories and output
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 out", longint'(u_out), 0);
        check("R1 valid", longint'(u_valid), 0);
        rst_n = 1'b1;
        model_reset();
        run_sample(ONE, 2 * ONE, ONE, ONE / 2, 0, 1'b0, "R1 fresh");

        busy_sample(ONE, 3 * ONE, ONE, ONE, ONE / 2, 1'b0);
        run_sample(ONE / 3, ONE / 2, ONE, ONE, 0, 1'b1, "R8 history");

        for (int n = 0; n < 40; n++) begin
            run_sample(rnd(3 * ONE), rnd(3 * ONE), 3277 + longint'($urandom_range(0, 127795)),
                       rnd(3 * ONE), rnd(ONE), 1'($urandom_range(0, 1)), "R6 R2");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule